// File: doc/BRIEF.md
# Indirect Shadowed PLL Configuration Register Bank

This block holds the configuration of a clock synthesizer behind a three-register host window. The host never addresses a configuration field directly. It loads a pointer register with a field address, a data register with a value, and then writes a two-bit command into a control register. The command either fetches the addressed field into the data register or stores the data register into the addressed field. Each command acts once and then clears itself.

The fields the host edits form a staging bank. The synthesizer is driven from a second, shadow bank. A transfer bit in the control register copies the whole staging bank into the shadow bank on every clock while it is set. A new divider set therefore reaches the outputs in a single step and never passes through a mixed state. While the bit is clear the outputs hold, whatever the host does to the staging bank.

Two synchronous active-low resets are provided. The hardware reset loads default values into both banks and clears the host window. The software reset clears only the host window and leaves both banks as they are.

Top module: `pll_cfg_bank`

## Requirements
- R1: After a hardware reset both banks hold the defaults, and the outputs show them: disable 0, fraction 0x0000, S 2, N 1, X 0, M 9, fraction-update 0, pad divider 3. The staging fields read back the same values.
- R2: Control bits [1:0] = 2'b10 store the data register into the staging field selected by the pointer register. Control bits [1:0] = 2'b01 load that field into the data register. The field map is: 3 disable, 4 fraction low byte, 5 fraction high byte, 6 S, 7 N, 8 X, 9 M, 0xA fraction-update, 0xC pad divider.
- R3: Command codes 2'b00 and 2'b11 change neither the staging bank nor the data register, and code 2'b11 stays in the control register.
- R4: A read (01) or write (10) command is carried out in the clock after it is written. The command field then reads 2'b00 on the following cycle.
- R5: A write command to an address outside the map changes no field. A read command from such an address loads zero into the data register.
- R6: A field narrower than 8 bits keeps only the low bits of a write. Its unused upper bits read back as zero.
- R7: While control bit 2 (transfer) is 1, every shadow field takes the staging value on the same clock, so all outputs change together one cycle after the transfer bit is seen.
- R8: While the transfer bit is 0, the outputs keep their values through any staging writes.
- R9: A software reset clears the pointer, data and control registers (including the transfer bit) and leaves both banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Synchronous active-low hardware reset, loads all defaults |
| sw_rst_n | input | 1 | Synchronous active-low software reset, clears the host window only |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Host write enable (with host_sel) |
| host_addr | input | 2 | Host window offset: 0 control, 1 pointer, 2 data, 3 reads zero |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr; the control register reads {5'b0, transfer, command} |
| pll_off | output | 1 | Shadow disable flag, 1 = synthesizer disabled, 0 = enabled |
| pll_frac | output | 16 | Shadow fractional value, high byte above low byte |
| pll_sdiv | output | 5 | Shadow S divider |
| pll_ndiv | output | 4 | Shadow N divider |
| pll_xdiv | output | 7 | Shadow X divider |
| pll_mdiv | output | 5 | Shadow M divider |
| pll_frac_upd | output | 1 | Shadow fraction-update flag |
| pll_pad_div | output | 4 | Shadow pad clock divider |

## Verification
The assertions check the following on every cycle:
- Commands clear themselves.
- Idle, reserved and unmapped commands leave the staging bank untouched.
- The unused upper bits of each field stay zero.
- Each read command lands in the data register.
- The shadow bank either mirrors the staging bank or holds still, as the transfer bit dictates.
- A software reset empties the host window.

Some properties only the directed scenarios can show:
- The default values themselves.
- The exact field map.
- That a whole divider set reaches the outputs on one edge.
- That a software reset keeps the programmed synthesizer settings.

// File: rtl/pllcfg_pkg.sv
// Package: shared constants, field map and command encoding for the
// indirect PLL configuration bank. Assumes 8-bit host data and at most
// 8-bit fields.
package pllcfg_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned PTR_W      = 8;
    localparam int unsigned HOST_OFS_W = 2;
    localparam int unsigned NUM_FLD    = 9;

    // Host window offsets
    localparam logic [HOST_OFS_W-1:0] OFS_CTRL = 2'd0;
    localparam logic [HOST_OFS_W-1:0] OFS_PTR  = 2'd1;
    localparam logic [HOST_OFS_W-1:0] OFS_DATA = 2'd2;

    localparam int unsigned CTRL_XFER_BIT = 2;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_RD   = 2'b01,
        CMD_WR   = 2'b10,
        CMD_RSVD = 2'b11
    } cmd_e;

    // Field indices into the banks
    localparam int unsigned IX_OFF  = 0;
    localparam int unsigned IX_FLO  = 1;
    localparam int unsigned IX_FHI  = 2;
    localparam int unsigned IX_S    = 3;
    localparam int unsigned IX_N    = 4;
    localparam int unsigned IX_X    = 5;
    localparam int unsigned IX_M    = 6;
    localparam int unsigned IX_UPD  = 7;
    localparam int unsigned IX_PAD  = 8;

    // Field address, width and default value, indexed as above
    localparam int unsigned FLD_ADDR  [NUM_FLD] = '{3, 4, 5, 6, 7, 8, 9, 10, 12};
    localparam int unsigned FLD_WIDTH [NUM_FLD] = '{1, 8, 8, 5, 4, 7, 5, 1, 4};
    localparam int unsigned FLD_RST   [NUM_FLD] = '{0, 0, 0, 2, 1, 0, 9, 0, 3};

    typedef logic [NUM_FLD-1:0][DATA_W-1:0] bank_t;

    // Mask of the implemented bits of a field of width w
    function automatic logic [DATA_W-1:0] fld_mask(input int unsigned w);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < DATA_W; b++) begin
            m[b] = (b < w);
        end
        return m;
    endfunction

endpackage

// File: rtl/pllcfg_host_regs.sv
// Host window: pointer, data and control registers plus command sequencing.
// A read or write command issues a one-cycle strobe to the staging bank and
// then clears itself. Assumes host writes take effect on the clock edge at
// which host_sel and host_we are high. Both resets clear this window.
module pllcfg_host_regs
    import pllcfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  hw_rst_n,
    input  logic                  sw_rst_n,
    input  logic                  host_sel,
    input  logic                  host_we,
    input  logic [HOST_OFS_W-1:0] host_addr,
    input  logic [DATA_W-1:0]     host_wdata,
    output logic [DATA_W-1:0]     host_rdata,
    input  logic [DATA_W-1:0]     fld_rdata,
    output logic [PTR_W-1:0]      ptr,
    output logic [DATA_W-1:0]     wr_value,
    output logic                  rd_strobe,
    output logic                  wr_strobe,
    output logic                  xfer
);

    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] data_q;
    cmd_e              cmd_q;
    logic              xfer_q;
    logic              host_wr;
    logic              wr_ctrl, wr_ptr, wr_data;
    logic              win_rst;

    // Decode host writes per register
    always_comb begin
        host_wr = host_sel && host_we;
        wr_ctrl = host_wr && (host_addr == OFS_CTRL);
        wr_ptr  = host_wr && (host_addr == OFS_PTR);
        wr_data = host_wr && (host_addr == OFS_DATA);
        win_rst = !hw_rst_n || !sw_rst_n;
    end

    // Window registers: host writes, read-command capture, command self-clear
    always_ff @(posedge clk) begin
        if (win_rst) begin
            ptr_q  <= '0;
            data_q <= '0;
            cmd_q  <= CMD_IDLE;
            xfer_q <= 1'b0;
        end else begin
            if (wr_ptr) begin
                ptr_q <= host_wdata;
            end
            if (wr_data) begin
                data_q <= host_wdata;
            end else if (cmd_q == CMD_RD) begin
                data_q <= fld_rdata;
            end
            if (wr_ctrl) begin
                cmd_q  <= cmd_e'(host_wdata[1:0]);
                xfer_q <= host_wdata[CTRL_XFER_BIT];
            end else if (cmd_q == CMD_RD || cmd_q == CMD_WR) begin
                cmd_q <= CMD_IDLE;
            end
        end
    end

    // Strobes are held off while the software reset is asserted
    always_comb begin
        rd_strobe = (cmd_q == CMD_RD) && sw_rst_n;
        wr_strobe = (cmd_q == CMD_WR) && sw_rst_n;
        ptr       = ptr_q;
        wr_value  = data_q;
        xfer      = xfer_q;
    end

    // Host read multiplexer
    always_comb begin
        unique case (host_addr)
            OFS_CTRL: host_rdata = {{(DATA_W-3){1'b0}}, xfer_q, cmd_q};
            OFS_PTR:  host_rdata = ptr_q;
            OFS_DATA: host_rdata = data_q;
            default:  host_rdata = '0;
        endcase
    end

    // R4: an executed command reads idle on the next cycle
    a_r4_cmd_selfclear: assert property (@(posedge clk) disable iff (win_rst)
        ((cmd_q == CMD_RD || cmd_q == CMD_WR) && !wr_ctrl) |=> (cmd_q == CMD_IDLE));

    // R2: a read command lands the selected field in the data register
    a_r2_read_lands: assert property (@(posedge clk) disable iff (win_rst)
        (rd_strobe && !wr_data) |=> (data_q == $past(fld_rdata)));

    // R9: software reset empties the window
    a_r9_sw_clear: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !sw_rst_n |=> (ptr_q == '0 && data_q == '0 && cmd_q == CMD_IDLE && !xfer_q));

endmodule

// File: rtl/pllcfg_stage_bank.sv
// Staging bank: one register per mapped field, written by the write strobe
// and read combinationally through the pointer. Assumes strobes are single
// cycle. Only the hardware reset loads defaults.
module pllcfg_stage_bank
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_value,
    output logic [DATA_W-1:0] fld_rdata,
    output bank_t             stage_q
);

    logic [NUM_FLD-1:0] hit;

    for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
        localparam logic [DATA_W-1:0] MASK = fld_mask(FLD_WIDTH[i]);
        localparam logic [DATA_W-1:0] RSTV = DATA_W'(FLD_RST[i]);

        // Address decode for this field
        assign hit[i] = (ptr == PTR_W'(FLD_ADDR[i]));

        // Field register: default on hardware reset, masked store on write
        always_ff @(posedge clk) begin
            if (!hw_rst_n) begin
                stage_q[i] <= RSTV;
            end else if (wr_strobe && hit[i]) begin
                stage_q[i] <= wr_value & MASK;
            end
        end

        // R6: unimplemented upper bits never hold ones
        a_r6_upper_zero: assert property (@(posedge clk) disable iff (!hw_rst_n)
            ((stage_q[i] & ~MASK) == '0));
    end

    // Read multiplexer; unmapped addresses return zero
    always_comb begin
        fld_rdata = '0;
        for (int i = 0; i < NUM_FLD; i++) begin
            if (hit[i]) begin
                fld_rdata = stage_q[i];
            end
        end
    end

    // R3: without a write strobe the staging bank is untouched
    a_r3_idle_no_change: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !wr_strobe |=> $stable(stage_q));

    // R5: a write to an unmapped address is dropped
    a_r5_unmapped_dropped: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (wr_strobe && hit == '0) |=> $stable(stage_q));

endmodule

// File: rtl/pllcfg_shadow_bank.sv
// Shadow bank: mirrors the whole staging bank on every clock while the
// transfer bit is set, otherwise holds. Only the hardware reset loads the
// same defaults as the staging bank.
module pllcfg_shadow_bank
    import pllcfg_pkg::*;
(
    input  logic  clk,
    input  logic  hw_rst_n,
    input  logic  xfer,
    input  bank_t stage_q,
    output bank_t shadow_q
);

    for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
        localparam logic [DATA_W-1:0] RSTV = DATA_W'(FLD_RST[i]);

        // Shadow field: default on reset, copy while transfer is set
        always_ff @(posedge clk) begin
            if (!hw_rst_n) begin
                shadow_q[i] <= RSTV;
            end else if (xfer) begin
                shadow_q[i] <= stage_q[i];
            end
        end
    end

    // R7: all fields take the staging values on the same edge
    a_r7_copy_all: assert property (@(posedge clk) disable iff (!hw_rst_n)
        xfer |=> (shadow_q == $past(stage_q)));

    // R8: without transfer the shadow bank holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !xfer |=> $stable(shadow_q));

endmodule

// File: rtl/pll_cfg_bank.sv
// Top: indirect, double-banked PLL configuration. The host window drives the
// staging bank through commands; the shadow bank feeds the synthesizer
// outputs. Assumes both resets are synchronous to clk.
module pll_cfg_bank
    import pllcfg_pkg::*;
(
    input  logic                         clk,
    input  logic                         hw_rst_n,
    input  logic                         sw_rst_n,
    input  logic                         host_sel,
    input  logic                         host_we,
    input  logic [HOST_OFS_W-1:0]        host_addr,
    input  logic [DATA_W-1:0]            host_wdata,
    output logic [DATA_W-1:0]            host_rdata,
    output logic                         pll_off,
    output logic [2*DATA_W-1:0]          pll_frac,
    output logic [FLD_WIDTH[IX_S]-1:0]   pll_sdiv,
    output logic [FLD_WIDTH[IX_N]-1:0]   pll_ndiv,
    output logic [FLD_WIDTH[IX_X]-1:0]   pll_xdiv,
    output logic [FLD_WIDTH[IX_M]-1:0]   pll_mdiv,
    output logic                         pll_frac_upd,
    output logic [FLD_WIDTH[IX_PAD]-1:0] pll_pad_div
);

    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] wr_value;
    logic [DATA_W-1:0] fld_rdata;
    logic              rd_strobe;
    logic              wr_strobe;
    logic              xfer;
    bank_t             stage_q;
    bank_t             shadow_q;
    logic              unused_shadow;
    logic              unused_rd;

    pllcfg_host_regs u_host (
        .clk        (clk),
        .hw_rst_n   (hw_rst_n),
        .sw_rst_n   (sw_rst_n),
        .host_sel   (host_sel),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .fld_rdata  (fld_rdata),
        .ptr        (ptr),
        .wr_value   (wr_value),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .xfer       (xfer)
    );

    pllcfg_stage_bank u_stage (
        .clk       (clk),
        .hw_rst_n  (hw_rst_n),
        .ptr       (ptr),
        .wr_strobe (wr_strobe),
        .wr_value  (wr_value),
        .fld_rdata (fld_rdata),
        .stage_q   (stage_q)
    );

    pllcfg_shadow_bank u_shadow (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .xfer     (xfer),
        .stage_q  (stage_q),
        .shadow_q (shadow_q)
    );

    // Slice the shadow fields onto the synthesizer outputs
    always_comb begin
        pll_off       = shadow_q[IX_OFF][0];
        pll_frac      = {shadow_q[IX_FHI], shadow_q[IX_FLO]};
        pll_sdiv      = shadow_q[IX_S][FLD_WIDTH[IX_S]-1:0];
        pll_ndiv      = shadow_q[IX_N][FLD_WIDTH[IX_N]-1:0];
        pll_xdiv      = shadow_q[IX_X][FLD_WIDTH[IX_X]-1:0];
        pll_mdiv      = shadow_q[IX_M][FLD_WIDTH[IX_M]-1:0];
        pll_frac_upd  = shadow_q[IX_UPD][0];
        pll_pad_div   = shadow_q[IX_PAD][FLD_WIDTH[IX_PAD]-1:0];
        unused_shadow = ^shadow_q;
        unused_rd     = rd_strobe;
    end

endmodule

// File: tb/pll_cfg_bank_bench.sv
`timescale 1ns/1ps
module pll_cfg_bank_bench;

    logic       clk = 1'b0;
    logic       hw_rst_n = 1'b0;
    logic       sw_rst_n = 1'b1;
    logic       host_sel = 1'b0;
    logic       host_we = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       pll_off;
    logic [15:0] pll_frac;
    logic [4:0] pll_sdiv;
    logic [3:0] pll_ndiv;
    logic [6:0] pll_xdiv;
    logic [4:0] pll_mdiv;
    logic       pll_frac_upd;
    logic [3:0] pll_pad_div;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit xfer_on = 1'b0;

    localparam logic [1:0] O_CTRL = 2'd0;
    localparam logic [1:0] O_PTR  = 2'd1;
    localparam logic [1:0] O_DATA = 2'd2;

    always #2 clk = ~clk;

    pll_cfg_bank u_pll_cfg_bank (
        .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst_n(sw_rst_n),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pll_off(pll_off), .pll_frac(pll_frac), .pll_sdiv(pll_sdiv),
        .pll_ndiv(pll_ndiv), .pll_xdiv(pll_xdiv), .pll_mdiv(pll_mdiv),
        .pll_frac_upd(pll_frac_upd), .pll_pad_div(pll_pad_div)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] ofs, input logic [7:0] v);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = ofs; host_wdata = v;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic peek(input logic [1:0] ofs, output logic [7:0] v);
        host_addr = ofs;
        #0.5;
        v = host_rdata;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] v);
        host_write(O_PTR, a);
        host_write(O_DATA, v);
        host_write(O_CTRL, {5'b0, xfer_on, 2'b10});
        @(negedge clk);
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] v);
        host_write(O_PTR, a);
        host_write(O_CTRL, {5'b0, xfer_on, 2'b01});
        @(negedge clk);
        peek(O_DATA, v);
    endtask

    task automatic check_outputs_default(input string req);
        check({req, " off"},  {31'd0, pll_off}, 32'd0);
        check({req, " frac"}, {16'd0, pll_frac}, 32'h0);
        check({req, " S"},    {27'd0, pll_sdiv}, 32'd2);
        check({req, " N"},    {28'd0, pll_ndiv}, 32'd1);
        check({req, " X"},    {25'd0, pll_xdiv}, 32'd0);
        check({req, " M"},    {27'd0, pll_mdiv}, 32'd9);
        check({req, " upd"},  {31'd0, pll_frac_upd}, 32'd0);
        check({req, " pad"},  {28'd0, pll_pad_div}, 32'd3);
    endtask

    // R1: defaults after hardware reset
    task automatic t_reset();
        logic [7:0] v;
        check_outputs_default("R1 outputs");
        peek(O_CTRL, v); check("R1 ctrl", {24'd0, v}, 32'd0);
        peek(O_PTR, v);  check("R1 ptr", {24'd0, v}, 32'd0);
        peek(O_DATA, v); check("R1 data", {24'd0, v}, 32'd0);
        cfg_read(8'd6, v);  check("R1 stage S", {24'd0, v}, 32'd2);
        cfg_read(8'd9, v);  check("R1 stage M", {24'd0, v}, 32'd9);
        cfg_read(8'd12, v); check("R1 stage pad", {24'd0, v}, 32'd3);
        cfg_read(8'd7, v);  check("R1 stage N", {24'd0, v}, 32'd1);
    endtask

    // R2, R4: write then read back, command self-clear
    task automatic t_write_read();
        logic [7:0] v;
        host_write(O_PTR, 8'd4);
        host_write(O_DATA, 8'hA5);
        host_write(O_CTRL, 8'h02);
        peek(O_CTRL, v); check("R4 cmd pending", {24'd0, v}, 32'h02);
        @(negedge clk);
        peek(O_CTRL, v); check("R4 cmd cleared", {24'd0, v}, 32'h00);
        cfg_write(8'd5, 8'h3C);
        host_write(O_DATA, 8'h00);
        cfg_read(8'd4, v); check("R2 frac lo", {24'd0, v}, 32'hA5);
        peek(O_CTRL, v); check("R4 read cleared", {24'd0, v}, 32'h00);
        cfg_read(8'd5, v); check("R2 frac hi", {24'd0, v}, 32'h3C);
        cfg_write(8'd8, 8'h5A);
        cfg_read(8'd8, v); check("R2 X", {24'd0, v}, 32'h5A);
        check_outputs_default("R8 held");
    endtask

    // R6: narrow fields
    task automatic t_narrow();
        logic [7:0] v;
        cfg_write(8'd6, 8'hFF);
        cfg_read(8'd6, v); check("R6 S trunc", {24'd0, v}, 32'h1F);
        cfg_write(8'd3, 8'hFE);
        cfg_read(8'd3, v); check("R6 off trunc", {24'd0, v}, 32'h00);
        cfg_write(8'd12, 8'hF6);
        cfg_read(8'd12, v); check("R6 pad trunc", {24'd0, v}, 32'h06);
    endtask

    // R5: unmapped addresses
    task automatic t_unmapped();
        logic [7:0] v;
        cfg_write(8'd11, 8'h55);
        cfg_write(8'd0, 8'h66);
        cfg_read(8'd11, v); check("R5 unmapped read", {24'd0, v}, 32'h00);
        cfg_read(8'd10, v); check("R5 neighbour upd", {24'd0, v}, 32'h00);
        cfg_read(8'd12, v); check("R5 neighbour pad", {24'd0, v}, 32'h06);
        cfg_read(8'd3, v);  check("R5 off untouched", {24'd0, v}, 32'h00);
    endtask

    // R3: idle and reserved commands
    task automatic t_reserved();
        logic [7:0] v;
        host_write(O_PTR, 8'd9);
        host_write(O_DATA, 8'h17);
        host_write(O_CTRL, 8'h03);
        repeat (3) @(negedge clk);
        peek(O_CTRL, v); check("R3 rsvd stays", {24'd0, v}, 32'h03);
        peek(O_DATA, v); check("R3 rsvd data kept", {24'd0, v}, 32'h17);
        host_write(O_CTRL, 8'h00);
        repeat (2) @(negedge clk);
        peek(O_DATA, v); check("R3 idle data kept", {24'd0, v}, 32'h17);
        cfg_read(8'd9, v); check("R3 M untouched", {24'd0, v}, 32'd9);
    endtask

    // R7, R8: atomic transfer and hold
    task automatic t_transfer();
        logic [7:0] v;
        host_write(O_CTRL, 8'h04);
        xfer_on = 1'b1;
        check("R7 before copy", {16'd0, pll_frac}, 32'h0);
        @(negedge clk);
        check("R7 frac", {16'd0, pll_frac}, 32'h3CA5);
        check("R7 S", {27'd0, pll_sdiv}, 32'h1F);
        check("R7 X", {25'd0, pll_xdiv}, 32'h5A);
        check("R7 pad", {28'd0, pll_pad_div}, 32'h6);
        check("R7 M", {27'd0, pll_mdiv}, 32'd9);
        cfg_write(8'd7, 8'h05);
        @(negedge clk);
        check("R7 follow N", {28'd0, pll_ndiv}, 32'h5);
        cfg_write(8'd3, 8'h01);
        @(negedge clk);
        check("R7 disable", {31'd0, pll_off}, 32'd1);
        xfer_on = 1'b0;
        host_write(O_CTRL, 8'h00);
        @(negedge clk);
        cfg_write(8'd9, 8'h11);
        cfg_write(8'd10, 8'h01);
        repeat (2) @(negedge clk);
        check("R8 M held", {27'd0, pll_mdiv}, 32'd9);
        check("R8 upd held", {31'd0, pll_frac_upd}, 32'd0);
        cfg_read(8'd9, v); check("R8 stage M", {24'd0, v}, 32'h11);
    endtask

    // R9: software reset
    task automatic t_swreset();
        logic [7:0] v;
        host_write(O_CTRL, 8'h04);
        @(negedge clk);
        host_write(O_PTR, 8'd6);
        host_write(O_DATA, 8'h44);
        host_write(O_CTRL, 8'h04);
        @(negedge clk);
        sw_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        sw_rst_n = 1'b1;
        @(negedge clk);
        peek(O_CTRL, v); check("R9 ctrl", {24'd0, v}, 32'h00);
        peek(O_PTR, v);  check("R9 ptr", {24'd0, v}, 32'h00);
        peek(O_DATA, v); check("R9 data", {24'd0, v}, 32'h00);
        check("R9 M kept", {27'd0, pll_mdiv}, 32'h11);
        check("R9 N kept", {28'd0, pll_ndiv}, 32'h5);
        check("R9 off kept", {31'd0, pll_off}, 32'd1);
        cfg_read(8'd9, v); check("R9 stage M", {24'd0, v}, 32'h11);
        cfg_read(8'd4, v); check("R9 stage lo", {24'd0, v}, 32'hA5);
    endtask

    // R1: second hardware reset restores defaults
    task automatic t_hw_again();
        logic [7:0] v;
        @(negedge clk);
        hw_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        hw_rst_n = 1'b1;
        @(negedge clk);
        check_outputs_default("R1 re-reset");
        cfg_read(8'd4, v); check("R1 re-reset stage lo", {24'd0, v}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        hw_rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_narrow();
        t_unmapped();
        t_reserved();
        t_transfer();
        t_swreset();
        t_hw_again();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule